// File: doc/BRIEF.md
# Uncore Event Counter Unit

This block is a bank of hardware event counters for a shared, non-core part of a chip. The unit takes a vector of event strobes from the logic around it. Each counter picks one strobe through its own 8-bit event code and adds one for every clock cycle in which that strobe is high. Counting is gated by a global run bit and by a per-counter enable bit.

A counter that passes its all-ones value wraps to zero and latches a status bit. A mask, in which a 1 blocks the bit, decides which status bits reach a single registered interrupt line. Software clears status bits by writing ones to a separate clear register.

All control, event-code, interrupt, version and counter registers are reached through a plain register port. The port has a write strobe, a byte address, 64-bit write data and combinational 64-bit read data. One build parameter chooses between two builds: sixteen 48-bit counters, or eight 64-bit counters.

Top module: `ucnt_unit`

## Requirements
- R1: After reset every counter reads 0, every event code reads 0xFF, the interrupt mask (0x0804) reads all ones over the counter bits, and the run register (0x1E00), the enable register (0x1E04), the status register (0x0808) and irq_o all read 0.
- R2: Counter n adds exactly one at each clock edge where run bit 0 of 0x1E00 is 1, enable bit n of 0x1E04 is 1 and the strobe picked by its code is high. In every other cycle it holds its value.
- R3: The 8-bit code of counter n sits in the 32-bit register at 0x1E80 + 4*(n/4), bits 8*(n%4)+7 down to 8*(n%4). Code c picks strobe evt_i[c]. Code 0xFF, and any code not below NUM_EVT, never counts.
- R4: Counter n is a 64-bit register at 0x1F00 + 8*n. A write loads the written value, and a write wins over an increment in the same cycle. In the 48-bit build, bits 63:48 read 0 and writes to them are ignored.
- R5: A counter that increments from all ones becomes 0 at that edge, and its status bit n in 0x0808 reads 1 from that edge on.
- R6: Writing to 0x080C clears each status bit whose write bit is 1 and leaves the others. A wrap in the same cycle as the clear keeps that bit set. Writes to 0x0808 have no effect.
- R7: A 1 in mask bit n blocks status bit n. irq_o is a register: it is 1 in the cycle after a cycle in which any unmasked status bit is 1, and 0 otherwise.
- R8: The read-only register at 0x1CF0 reads 1 in the 16 x 48-bit build and 2 in the 8 x 64-bit build. Addresses that map to no register read 0, including counter and code slots beyond the built counter count.
- R9: With WIDE = 0 the unit has 16 counters of 48 bits. With WIDE = 1 it has 8 counters of 64 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | NUM_EVT | Event strobes, one per event code |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 13 | Register byte address |
| reg_wdata_i | input | 64 | Register write data |
| reg_rdata_o | output | 64 | Register read data for reg_addr_i, combinational |
| irq_o | output | 1 | Registered interrupt line |

## Verification
The bench builds two copies of the unit side by side on shared inputs. One uses WIDE = 0 and the other WIDE = 1, and both use the full 256-strobe event vector. The 48-bit copy receives every one of the 256 event codes on one counter, and a one-hot sweep gives every counter a different count, so a wrong code lane or strobe index shows up at once. Both copies have counters preloaded near all ones, which brings wrap, status latching, clear-versus-wrap collision, the read-as-zero upper bits and the slots missing from the 8-counter build within a few cycles.

// File: rtl/ucnt_pkg.sv
package ucnt_pkg;

    localparam int          ADDR_W    = 13;
    localparam logic [12:0] A_IMASK   = 13'h0804;
    localparam logic [12:0] A_ISTAT   = 13'h0808;
    localparam logic [12:0] A_ICLR    = 13'h080C;
    localparam logic [12:0] A_VER     = 13'h1CF0;
    localparam logic [12:0] A_RUN     = 13'h1E00;
    localparam logic [12:0] A_CEN     = 13'h1E04;
    localparam logic [12:0] A_CODE    = 13'h1E80;
    localparam logic [12:0] A_CNT     = 13'h1F00;
    localparam logic [7:0]  EVT_NONE  = 8'hFF;
    localparam int          CODE_W    = 8;
    localparam int          EVT_SPACE = 256;

    function automatic int num_counters(input bit wide);
        return wide ? 8 : 16;
    endfunction

    function automatic int counter_bits(input bit wide);
        return wide ? 64 : 48;
    endfunction

    function automatic logic [31:0] build_id(input bit wide);
        return wide ? 32'd2 : 32'd1;
    endfunction

endpackage

// File: rtl/ucnt_event_pick.sv
module ucnt_event_pick
    import ucnt_pkg::*;
#(
    parameter int NUM_EVT = 256
) (
    input  logic [NUM_EVT-1:0] evt_i,
    input  logic [CODE_W-1:0]  code_i,
    output logic               hit_o
);

    logic [EVT_SPACE-1:0] evt_wide;

    always_comb begin
        evt_wide = EVT_SPACE'(evt_i);
        hit_o    = (code_i != EVT_NONE) && evt_wide[code_i];
    end

endmodule

// File: rtl/ucnt_counter.sv
module ucnt_counter #(
    parameter int CW = 48
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc_i,
    input  logic          ld_i,
    input  logic [CW-1:0] ld_val_i,
    output logic [CW-1:0] cnt_o,
    output logic          wrap_o
);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        wrap_o = 1'b0;
        if (ld_i) begin
            st_d.cnt = ld_val_i;
        end else if (inc_i) begin
            st_d.cnt = st_q.cnt + 1'b1;
            wrap_o   = (st_q.cnt == {CW{1'b1}});
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cnt <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o = st_q.cnt;

    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc_i && !ld_i) |=> $stable(cnt_o));

    a_r4_load: assert property (@(posedge clk) disable iff (!rst_n)
        ld_i |=> (cnt_o == $past(ld_val_i)));

    a_r5_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_o |=> (cnt_o == '0));

endmodule

// File: rtl/ucnt_irq.sv
module ucnt_irq #(
    parameter int NCNT = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NCNT-1:0] wrap_i,
    input  logic            clr_we_i,
    input  logic [NCNT-1:0] clr_bits_i,
    input  logic [NCNT-1:0] mask_i,
    output logic [NCNT-1:0] status_o,
    output logic            irq_o
);

    typedef struct packed {
        logic [NCNT-1:0] status;
        logic            irq;
    } irq_state_t;

    irq_state_t st_d, st_q;
    logic [NCNT-1:0] clr_eff;

    always_comb begin
        clr_eff     = clr_we_i ? clr_bits_i : '0;
        st_d.status = (st_q.status & ~clr_eff) | wrap_i;
        st_d.irq    = |(st_q.status & ~mask_i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.status <= '0;
            st_q.irq    <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign status_o = st_q.status;
    assign irq_o    = st_q.irq;

    a_r5_status_set: assert property (@(posedge clk) disable iff (!rst_n)
        (|wrap_i) |=> ((status_o & $past(wrap_i)) == $past(wrap_i)));

    a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we_i && |(clr_bits_i & ~wrap_i)) |=> ((status_o & $past(clr_bits_i & ~wrap_i)) == '0));

    a_r7_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_o & ~mask_i) == '0) |=> !irq_o);

    a_r7_raise: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_o & ~mask_i) != '0) |=> irq_o);

endmodule

// File: rtl/ucnt_unit.sv
module ucnt_unit
    import ucnt_pkg::*;
#(
    parameter bit WIDE    = 1'b0,
    parameter int NUM_EVT = 256
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] evt_i,
    input  logic               reg_we_i,
    input  logic [12:0]        reg_addr_i,
    input  logic [63:0]        reg_wdata_i,
    output logic [63:0]        reg_rdata_o,
    output logic               irq_o
);

    localparam int NCNT  = num_counters(WIDE);
    localparam int CW    = counter_bits(WIDE);
    localparam int NCODE = NCNT / 4;
    localparam logic [12:0] CNT_END  = A_CNT + 13'(8 * NCNT);
    localparam logic [12:0] CODE_END = A_CODE + 13'(4 * NCODE);

    typedef struct packed {
        logic                   run;
        logic [NCNT-1:0]        en;
        logic [NCNT-1:0]        mask;
        logic [NCNT*CODE_W-1:0] codes;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [12:0]     cnt_off, code_off;
    logic            cnt_hit, code_hit;
    logic [9:0]      cnt_idx;
    logic [10:0]     code_idx;
    logic [NCNT-1:0] evt_hit, inc, ld, wrap, status;
    logic [CW-1:0]   cnt_val [NCNT];
    logic            unused_low;

    // address decode for the counter and event-code windows
    always_comb begin
        cnt_off  = reg_addr_i - A_CNT;
        code_off = reg_addr_i - A_CODE;
        cnt_hit  = (reg_addr_i >= A_CNT) && (reg_addr_i < CNT_END) && (reg_addr_i[2:0] == 3'd0);
        code_hit = (reg_addr_i >= A_CODE) && (reg_addr_i < CODE_END) && (reg_addr_i[1:0] == 2'd0);
        cnt_idx  = cnt_off[12:3];
        code_idx = code_off[12:2];
    end

    assign unused_low = ^{cnt_off[2:0], code_off[1:0]};

    // next-state of the control registers
    always_comb begin
        ctl_d = ctl_q;
        if (reg_we_i) begin
            if (reg_addr_i == A_RUN)   ctl_d.run  = reg_wdata_i[0];
            if (reg_addr_i == A_CEN)   ctl_d.en   = reg_wdata_i[NCNT-1:0];
            if (reg_addr_i == A_IMASK) ctl_d.mask = reg_wdata_i[NCNT-1:0];
            for (int r = 0; r < NCODE; r++) begin
                if (code_hit && (code_idx == 11'(r))) begin
                    ctl_d.codes[32*r +: 32] = reg_wdata_i[31:0];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q.run   <= 1'b0;
            ctl_q.en    <= '0;
            ctl_q.mask  <= '1;
            ctl_q.codes <= '1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    for (genvar n = 0; n < NCNT; n++) begin : g_cnt
        ucnt_event_pick #(
            .NUM_EVT (NUM_EVT)
        ) u_pick (
            .evt_i  (evt_i),
            .code_i (ctl_q.codes[CODE_W*n +: CODE_W]),
            .hit_o  (evt_hit[n])
        );

        assign inc[n] = ctl_q.run & ctl_q.en[n] & evt_hit[n];
        assign ld[n]  = reg_we_i & cnt_hit & (cnt_idx == 10'(n));

        ucnt_counter #(
            .CW (CW)
        ) u_counter (
            .clk      (clk),
            .rst_n    (rst_n),
            .inc_i    (inc[n]),
            .ld_i     (ld[n]),
            .ld_val_i (reg_wdata_i[CW-1:0]),
            .cnt_o    (cnt_val[n]),
            .wrap_o   (wrap[n])
        );
    end

    ucnt_irq #(
        .NCNT (NCNT)
    ) u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .wrap_i     (wrap),
        .clr_we_i   (reg_we_i && (reg_addr_i == A_ICLR)),
        .clr_bits_i (reg_wdata_i[NCNT-1:0]),
        .mask_i     (ctl_q.mask),
        .status_o   (status),
        .irq_o      (irq_o)
    );

    // read mux
    always_comb begin
        reg_rdata_o = '0;
        case (reg_addr_i)
            A_RUN:   reg_rdata_o = 64'(ctl_q.run);
            A_CEN:   reg_rdata_o = 64'(ctl_q.en);
            A_IMASK: reg_rdata_o = 64'(ctl_q.mask);
            A_ISTAT: reg_rdata_o = 64'(status);
            A_VER:   reg_rdata_o = 64'(build_id(WIDE));
            default: reg_rdata_o = '0;
        endcase
        for (int r = 0; r < NCODE; r++) begin
            if (code_hit && (code_idx == 11'(r))) reg_rdata_o = 64'(ctl_q.codes[32*r +: 32]);
        end
        for (int n = 0; n < NCNT; n++) begin
            if (cnt_hit && (cnt_idx == 10'(n))) reg_rdata_o = 64'(cnt_val[n]);
        end
    end

    if (!WIDE) begin : g_raz
        a_r4_upper_raz: assert property (@(posedge clk) disable iff (!rst_n)
            cnt_hit |-> (reg_rdata_o[63:48] == 16'd0));
    end

    a_r6_stat_ro: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we_i && (reg_addr_i == A_ISTAT)) |=> ((status & $past(status)) == $past(status)));

    a_r2_no_run: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_q.run && !reg_we_i) |=> $stable(wrap == '0 ? status : status));

endmodule

// File: tb/ucnt_unit_tb.sv
`timescale 1ns/1ps
module ucnt_unit_tb;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [255:0] ev = '0;
    logic         we = 1'b0;
    logic [12:0]  addr = '0;
    logic [63:0]  wdata = '0;
    logic [63:0]  rd_n, rd_w;
    logic         irq_n, irq_w;
    int           total = 0;
    int           fails = 0;

    always #2.5 clk = ~clk;

    ucnt_unit #(.WIDE(1'b0), .NUM_EVT(256)) u_dut (
        .clk(clk), .rst_n(rst_n), .evt_i(ev), .reg_we_i(we), .reg_addr_i(addr),
        .reg_wdata_i(wdata), .reg_rdata_o(rd_n), .irq_o(irq_n));

    ucnt_unit #(.WIDE(1'b1), .NUM_EVT(256)) u_dut_wide (
        .clk(clk), .rst_n(rst_n), .evt_i(ev), .reg_we_i(we), .reg_addr_i(addr),
        .reg_wdata_i(wdata), .reg_rdata_o(rd_w), .irq_o(irq_w));

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; we = 1'b0; ev = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [12:0] a, input logic [63:0] d);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [12:0] a, output logic [63:0] vn, output logic [63:0] vw);
        @(negedge clk);
        addr = a;
        #0.5;
        vn = rd_n; vw = rd_w;
    endtask

    task automatic pulse(input logic [255:0] m, input int k);
        @(negedge clk);
        ev = m;
        repeat (k) @(negedge clk);
        ev = '0;
    endtask

    function automatic logic [12:0] cnt_a(input int n);
        return 13'h1F00 + 13'(8 * n);
    endfunction

    initial begin
        #(5.0 * 150000);
        total++; fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        logic [63:0] vn, vw;
        do_reset();

        // R1: reset state of both builds
        rd(13'h1E00, vn, vw); chk("R1 run", vn, 0); chk("R1 run wide", vw, 0);
        rd(13'h1E04, vn, vw); chk("R1 enable", vn, 0); chk("R1 enable wide", vw, 0);
        rd(13'h0804, vn, vw); chk("R1 mask", vn, 64'hFFFF); chk("R1 mask wide", vw, 64'hFF);
        rd(13'h0808, vn, vw); chk("R1 status", vn, 0); chk("R1 status wide", vw, 0);
        rd(13'h1E80, vn, vw); chk("R1 codes", vn, 64'hFFFF_FFFF); chk("R1 codes wide", vw, 64'hFFFF_FFFF);
        for (int n = 0; n < 16; n++) begin
            rd(cnt_a(n), vn, vw); chk("R1 counter", vn, 0);
        end
        chk("R1 irq", 64'(irq_n), 0); chk("R1 irq wide", 64'(irq_w), 0);

        // R3: every code on counter 0, with a neighbour strobe as decoy
        wr(13'h1E00, 1); wr(13'h1E04, 1);
        for (int c = 0; c < 256; c++) begin
            wr(13'h1E80, {32'h0, 24'hFFFFFF, 8'(c)});
            wr(cnt_a(0), 0);
            pulse(256'(1) << ((c + 1) % 256), 2);
            pulse(256'(1) << c, 1);
            rd(cnt_a(0), vn, vw);
            chk($sformatf("R3 code %0d", c), vn, (c == 255) ? 64'd0 : 64'd1);
        end

        // R2 + R9: one-hot sweep, distinct count per counter
        do_reset();
        wr(13'h1E00, 1); wr(13'h1E04, 64'hFFFF);
        for (int r = 0; r < 4; r++)
            wr(13'h1E80 + 13'(4 * r), {32'h0, 8'(4*r+3), 8'(4*r+2), 8'(4*r+1), 8'(4*r)});
        for (int n = 0; n < 16; n++) pulse(256'(1) << n, n + 1);
        for (int n = 0; n < 16; n++) begin
            rd(cnt_a(n), vn, vw);
            chk($sformatf("R2 sweep n=%0d", n), vn, 64'(n + 1));
            if (n < 8) chk($sformatf("R9 wide sweep n=%0d", n), vw, 64'(n + 1));
        end
        wr(13'h1E04, 64'h5555);
        pulse(256'hFFFF, 3);
        for (int n = 0; n < 16; n++) begin
            rd(cnt_a(n), vn, vw);
            chk($sformatf("R2 enable n=%0d", n), vn, 64'(n + 1 + ((n % 2 == 0) ? 3 : 0)));
            if (n < 8) chk($sformatf("R2 wide enable n=%0d", n), vw, 64'(n + 1 + ((n % 2 == 0) ? 3 : 0)));
        end
        wr(13'h1E00, 0);
        pulse(256'hFFFF, 2);
        for (int n = 0; n < 16; n++) begin
            rd(cnt_a(n), vn, vw);
            chk($sformatf("R2 run off n=%0d", n), vn, 64'(n + 1 + ((n % 2 == 0) ? 3 : 0)));
        end

        // R8: version and missing slots
        rd(13'h1CF0, vn, vw); chk("R8 version", vn, 1); chk("R8 version wide", vw, 2);
        rd(cnt_a(8), vn, vw); chk("R8 counter8", vn, 12); chk("R8 wide counter8 absent", vw, 0);
        rd(13'h1E88, vn, vw); chk("R8 code reg2", vn, 64'h0B0A_0908); chk("R8 wide code reg2 absent", vw, 0);
        rd(13'h0000, vn, vw); chk("R8 unmapped", vn, 0); chk("R8 unmapped wide", vw, 0);

        // R4 + R5: upper bits and wrap
        wr(13'h1E00, 1); wr(13'h1E04, 64'hFFFF);
        wr(cnt_a(3), 64'hFFFF_FFFF_FFFF_FFF0);
        rd(cnt_a(3), vn, vw);
        chk("R4 upper raz", vn, 64'h0000_FFFF_FFFF_FFF0); chk("R4 wide full", vw, 64'hFFFF_FFFF_FFFF_FFF0);
        pulse(256'h8, 15);
        rd(cnt_a(3), vn, vw);
        chk("R5 before wrap", vn, 64'h0000_FFFF_FFFF_FFFF); chk("R5 wide before wrap", vw, 64'hFFFF_FFFF_FFFF_FFFF);
        rd(13'h0808, vn, vw); chk("R5 no status yet", vn, 0);
        pulse(256'h8, 1);
        rd(cnt_a(3), vn, vw); chk("R5 wrapped", vn, 0); chk("R5 wide wrapped", vw, 0);
        rd(13'h0808, vn, vw); chk("R5 status", vn, 8); chk("R5 wide status", vw, 8);
        chk("R7 masked irq", 64'(irq_n), 0); chk("R7 masked irq wide", 64'(irq_w), 0);

        // R7: unmask, registered irq
        wr(13'h0804, 64'hFFF7);
        chk("R7 irq lag", 64'(irq_n), 0);
        @(negedge clk);
        chk("R7 irq high", 64'(irq_n), 1); chk("R7 irq high wide", 64'(irq_w), 1);

        // R6: clear other bit, write status, clear own bit
        wr(13'h080C, 4);
        rd(13'h0808, vn, vw); chk("R6 other clear", vn, 8);
        wr(13'h0808, 64'hFFFF);
        rd(13'h0808, vn, vw); chk("R6 status ro", vn, 8);
        wr(13'h0808, 0);
        rd(13'h0808, vn, vw); chk("R6 status ro zero", vn, 8);
        wr(13'h080C, 8);
        chk("R7 irq holds one cycle", 64'(irq_n), 1);
        #0.5;
        rd(13'h0808, vn, vw); chk("R6 cleared", vn, 0); chk("R6 wide cleared", vw, 0);
        chk("R7 irq low", 64'(irq_n), 0);

        // R6: wrap and clear collide
        wr(cnt_a(3), 64'hFFFF_FFFF_FFFF_FFFF);
        @(negedge clk);
        we = 1'b1; addr = 13'h080C; wdata = 8; ev = 256'h8;
        @(negedge clk);
        we = 1'b0; ev = '0;
        rd(13'h0808, vn, vw); chk("R6 wrap wins", vn, 8); chk("R6 wide wrap wins", vw, 8);
        rd(cnt_a(3), vn, vw); chk("R5 collide wrapped", vn, 0);

        // R4: write wins over increment
        @(negedge clk);
        we = 1'b1; addr = cnt_a(3); wdata = 100; ev = 256'h8;
        @(negedge clk);
        we = 1'b0; ev = '0;
        rd(cnt_a(3), vn, vw); chk("R4 write wins", vn, 100); chk("R4 wide write wins", vw, 100);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule